// File: doc/BRIEF.md
# System Sleep State Sequencer

This block holds the platform power state (S0, S3, S4 or S5) and drives three active-low sleep lines that switch off progressively deeper parts of the board. Software puts the platform to sleep with one configuration write that carries a sleep-enable bit and a target sleep type. Three hardware causes force the deepest state: a power button held past a programmable number of slow timebase ticks, a thermal-trip input while running, and a watchdog expiry. A qualified wake pulse brings the machine back to S0 and sets a sticky wake-status flag. While the low-battery input is high, wakes are held back and remembered.

A deep power-good input marks a power loss. While it is low, all sleep lines are driven asserted, requests are ignored and the button and alarm status flags are cleared. The state held when power dropped is remembered. When power returns, a policy bit selects the resume state. All pins are plain level or single-cycle pulse controls. No data stream crosses the boundary, so there is no valid/ready handshake and no back-pressure.

Top module: `sleep_seq_top`

## Requirements
- R1: After reset the state is S0 (code 0 on `state_o`), all three sleep lines are high, and the wake, button and alarm status flags are 0.
- R2: State codes on `state_o` are S0=0, S3=1, S4=2, S5=3. In S3 only `slp_a_n_o` is low. In S4 `slp_a_n_o` and `slp_b_n_o` are low. In S5 all three are low. In S0 all three are high.
- R3: A write (`cfg_wr_i` high) with `cfg_en_i`=1 and a nonzero `cfg_type_i` while in S0 moves the state to the code on `cfg_type_i` at the next edge. A write with `cfg_en_i`=0, a write with type 0, and any write outside S0 leave the state unchanged.
- R4: With the button held, the override fires on the (HOLD_TICKS+1)-th `tick_i` pulse and forces S5 at that edge, from any state. It fires at most once per press.
- R5: `therm_trip_i` in S0 forces S5 at the next edge. In S3, S4 or S5 it has no effect.
- R6: `wdt_expire_i` forces S5 at the next edge from any state.
- R7: A `wake_i` pulse in S3, S4 or S5 with low battery deasserted returns the state to S0 at the next edge and sets `wake_sts_o`.
- R8: While `low_batt_i` is high, no wake is taken. A wake seen during that time is remembered and taken at the edge where `low_batt_i` is first sampled low.
- R9: `wake_sts_clr_i` clears `wake_sts_o` at the next edge. A wake taken in the same cycle wins and leaves it set.
- R10: From the edge after `dpwr_good_i` is sampled low until power returns, all sleep lines are low and the state does not change.
- R11: At the edge where `dpwr_good_i` is sampled high again, the state becomes S0 if `apl_en_i`=0. If `apl_en_i`=1, it becomes S4 when the state at the loss was S4, and S5 otherwise.
- R12: `pbtn_sts_o` is set on the button's press edge and `rtc_sts_o` on an `rtc_alarm_i` pulse. Both are cleared while `dpwr_good_i` is low.
- R13: An override or watchdog expiry in the same cycle as a wake in a sleep state wins: the state goes to S5 and `wake_sts_o` is not set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_wr_i | input | 1 | Configuration write strobe |
| cfg_en_i | input | 1 | Sleep-enable bit of the write |
| cfg_type_i | input | 2 | Sleep-type field of the write |
| tick_i | input | 1 | Slow timebase enable for the hold counter |
| pwr_btn_i | input | 1 | Power button pressed (active high) |
| therm_trip_i | input | 1 | Thermal trip |
| wdt_expire_i | input | 1 | Watchdog timeout |
| wake_i | input | 1 | Qualified wake pulse |
| low_batt_i | input | 1 | Low battery, blocks wakes |
| dpwr_good_i | input | 1 | Deep power good, low means power lost |
| apl_en_i | input | 1 | After-power-loss policy bit |
| wake_sts_clr_i | input | 1 | Write-one-to-clear pulse for wake status |
| rtc_alarm_i | input | 1 | RTC alarm pulse |
| state_o | output | 2 | Current state code |
| slp_a_n_o | output | 1 | Sleep line asserted in S3, S4, S5 |
| slp_b_n_o | output | 1 | Sleep line asserted in S4, S5 |
| slp_c_n_o | output | 1 | Sleep line asserted in S5 |
| wake_sts_o | output | 1 | Sticky wake status |
| pbtn_sts_o | output | 1 | Power button status |
| rtc_sts_o | output | 1 | RTC alarm status |

## Verification
Software entry is tried with each nonzero sleep type, with the enable bit clear, with type 0, and while already asleep. These patterns separate a correct type decode and S0-only gating from a design that reacts to any write. The hold counter is stepped one tick at a time to pin the exact firing tick, then kept held to show it fires only once per press. Wakes are issued with low battery both high and low, and together with a forced shutdown, to separate deferral and priority. Power loss is entered from S0, S3, S4 and S5 under both policy values, which tells the S4 exception apart from the plain S5 and S0 outcomes.

// File: rtl/sleep_seq_pkg.sv
package sleep_seq_pkg;

  typedef enum logic [1:0] {
    ST_S0 = 2'd0,
    ST_S3 = 2'd1,
    ST_S4 = 2'd2,
    ST_S5 = 2'd3
  } pstate_t;

  // Asserted (active-high) view of the sleep lines: {c, b, a}
  function automatic logic [2:0] sleep_lines(pstate_t s);
    case (s)
      ST_S3:   return 3'b001;
      ST_S4:   return 3'b011;
      ST_S5:   return 3'b111;
      default: return 3'b000;
    endcase
  endfunction

endpackage

// File: rtl/btn_hold_ctr.sv
module btn_hold_ctr #(
  parameter int HOLD_TICKS = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic btn_i,
  input  logic tick_i,
  output logic ovr_o
);
  localparam int CW = $clog2(HOLD_TICKS + 1);
  localparam logic [CW-1:0] TERM = CW'(HOLD_TICKS);

  logic [CW-1:0] cnt;
  logic          fired;

  assign ovr_o = btn_i & tick_i & ~fired & (cnt == TERM);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt   <= '0;
      fired <= 1'b0;
    end else if (!btn_i) begin
      cnt   <= '0;
      fired <= 1'b0;
    end else if (tick_i) begin
      if (cnt != TERM) cnt <= cnt + CW'(1);
      if (ovr_o) fired <= 1'b1;
    end
  end

  // R4
  r4_once_per_press_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovr_o |=> !ovr_o);

  // R4
  r4_needs_button_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovr_o |-> (btn_i && $past(btn_i)));

endmodule

// File: rtl/wake_gate.sv
module wake_gate (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sleeping_i,
  input  logic blocked_i,
  input  logic kill_i,
  input  logic wake_i,
  output logic go_o
);
  logic pend;

  assign go_o = sleeping_i & ~blocked_i & ~kill_i & (wake_i | pend);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend <= 1'b0;
    else         pend <= sleeping_i & ~go_o & ~kill_i & (pend | wake_i);
  end

  // R8
  r8_blocked_no_wake_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    blocked_i |-> !go_o);

  // R8
  r8_deferred_taken_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sleeping_i && $past(sleeping_i) && $past(wake_i) && $past(blocked_i) && !$past(kill_i)
     && !blocked_i && !kill_i) |-> go_o);

endmodule

// File: rtl/pwr_loss_policy.sv
module pwr_loss_policy
  import sleep_seq_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    dpg_i,
  input  logic    apl_en_i,
  input  pstate_t cur_i,
  output logic    in_loss_o,
  output logic    resume_o,
  output pstate_t resume_state_o
);
  pstate_t loss_state;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      in_loss_o  <= 1'b0;
      loss_state <= ST_S0;
    end else begin
      in_loss_o <= ~dpg_i;
      if (!in_loss_o && !dpg_i) loss_state <= cur_i;
    end
  end

  assign resume_o = in_loss_o & dpg_i;

  always_comb begin
    if (!apl_en_i)                resume_state_o = ST_S0;
    else if (loss_state == ST_S4) resume_state_o = ST_S4;
    else                          resume_state_o = ST_S5;
  end

  // R10
  r10_loss_follows_dpg_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dpg_i |=> in_loss_o);

endmodule

// File: rtl/sleep_seq_top.sv
module sleep_seq_top
  import sleep_seq_pkg::*;
#(
  parameter int HOLD_TICKS = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       cfg_wr_i,
  input  logic       cfg_en_i,
  input  logic [1:0] cfg_type_i,
  input  logic       tick_i,
  input  logic       pwr_btn_i,
  input  logic       therm_trip_i,
  input  logic       wdt_expire_i,
  input  logic       wake_i,
  input  logic       low_batt_i,
  input  logic       dpwr_good_i,
  input  logic       apl_en_i,
  input  logic       wake_sts_clr_i,
  input  logic       rtc_alarm_i,
  output logic [1:0] state_o,
  output logic       slp_a_n_o,
  output logic       slp_b_n_o,
  output logic       slp_c_n_o,
  output logic       wake_sts_o,
  output logic       pbtn_sts_o,
  output logic       rtc_sts_o
);
  pstate_t state, state_nx, resume_state;
  logic    ovr, in_loss, resume, wake_go, force_s5, sw_go, frozen, btn_q;
  logic [2:0] lines;

  btn_hold_ctr #(.HOLD_TICKS(HOLD_TICKS)) u_hold (
    .clk_i (clk_i), .rst_ni(rst_ni), .btn_i(pwr_btn_i), .tick_i(tick_i), .ovr_o(ovr)
  );

  pwr_loss_policy u_loss (
    .clk_i(clk_i), .rst_ni(rst_ni), .dpg_i(dpwr_good_i), .apl_en_i(apl_en_i),
    .cur_i(state), .in_loss_o(in_loss), .resume_o(resume), .resume_state_o(resume_state)
  );

  assign frozen   = in_loss | ~dpwr_good_i;
  assign force_s5 = ovr | wdt_expire_i | (therm_trip_i & (state == ST_S0));
  assign sw_go    = cfg_wr_i & cfg_en_i & (state == ST_S0) & (cfg_type_i != 2'd0);

  wake_gate u_wake (
    .clk_i(clk_i), .rst_ni(rst_ni), .sleeping_i(state != ST_S0), .blocked_i(low_batt_i),
    .kill_i(frozen | force_s5), .wake_i(wake_i), .go_o(wake_go)
  );

  always_comb begin
    state_nx = state;
    if (resume)        state_nx = resume_state;
    else if (frozen)   state_nx = state;
    else if (force_s5) state_nx = ST_S5;
    else if (wake_go)  state_nx = ST_S0;
    else if (sw_go)    state_nx = pstate_t'(cfg_type_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state      <= ST_S0;
      wake_sts_o <= 1'b0;
      pbtn_sts_o <= 1'b0;
      rtc_sts_o  <= 1'b0;
      btn_q      <= 1'b0;
    end else begin
      state <= state_nx;
      btn_q <= pwr_btn_i;
      if (wake_go)             wake_sts_o <= 1'b1;
      else if (wake_sts_clr_i) wake_sts_o <= 1'b0;
      if (!dpwr_good_i) begin
        pbtn_sts_o <= 1'b0;
        rtc_sts_o  <= 1'b0;
      end else begin
        if (pwr_btn_i && !btn_q) pbtn_sts_o <= 1'b1;
        if (rtc_alarm_i)         rtc_sts_o  <= 1'b1;
      end
    end
  end

  assign lines     = in_loss ? 3'b111 : sleep_lines(state);
  assign slp_a_n_o = ~lines[0];
  assign slp_b_n_o = ~lines[1];
  assign slp_c_n_o = ~lines[2];
  assign state_o   = state;

  // R2
  r2_s3_lines_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 2'd1 && !in_loss) |-> (!slp_a_n_o && slp_b_n_o && slp_c_n_o));

  // R5
  r5_thermal_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (therm_trip_i && state_o == 2'd0 && dpwr_good_i && !in_loss) |=> state_o == 2'd3);

  // R7
  r7_wake_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o != 2'd0 && wake_i && !low_batt_i && !ovr && !wdt_expire_i
     && dpwr_good_i && !in_loss) |=> (state_o == 2'd0 && wake_sts_o));

  // R10
  r10_lines_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_loss |-> (!slp_a_n_o && !slp_b_n_o && !slp_c_n_o));

  // R12
  r12_sts_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dpwr_good_i |=> (!pbtn_sts_o && !rtc_sts_o));

  // R13
  r13_force_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o != 2'd0 && wdt_expire_i && dpwr_good_i && !in_loss) |=> state_o == 2'd3);

endmodule

// File: tb/tb_sleep_seq_top.sv
module tb_sleep_seq_top;
  localparam int HOLD = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_wr = 0, cfg_en = 0, tick = 0, btn = 0, therm = 0, wdt = 0, wake = 0;
  logic low_batt = 0, dpg = 1, apl = 0, wclr = 0, rtc = 0;
  logic [1:0] cfg_type = 0;
  logic [1:0] st;
  logic sa, sb, sc, wsts, psts, rsts;
  int total = 0, bad = 0;

  always #10 clk = ~clk;

  sleep_seq_top #(.HOLD_TICKS(HOLD)) dut (
    .clk_i(clk), .rst_ni(rst_n), .cfg_wr_i(cfg_wr), .cfg_en_i(cfg_en), .cfg_type_i(cfg_type),
    .tick_i(tick), .pwr_btn_i(btn), .therm_trip_i(therm), .wdt_expire_i(wdt), .wake_i(wake),
    .low_batt_i(low_batt), .dpwr_good_i(dpg), .apl_en_i(apl), .wake_sts_clr_i(wclr),
    .rtc_alarm_i(rtc), .state_o(st), .slp_a_n_o(sa), .slp_b_n_o(sb), .slp_c_n_o(sc),
    .wake_sts_o(wsts), .pbtn_sts_o(psts), .rtc_sts_o(rsts)
  );

  task automatic check(string req, int act, int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(); @(negedge clk); endtask

  function automatic int lines_n(); return {sc, sb, sa}; endfunction

  task automatic sw_write(logic en, logic [1:0] ty);
    cfg_wr = 1; cfg_en = en; cfg_type = ty; cyc();
    cfg_wr = 0; cfg_en = 0; cfg_type = 0;
  endtask

  task automatic pulse_wake(); wake = 1; cyc(); wake = 0; endtask

  task automatic clear_wsts(); wclr = 1; cyc(); wclr = 0; endtask

  task automatic t_reset();
    check("R1 state", st, 0);
    check("R1 lines", lines_n(), 3'b111);
    check("R1 status", {wsts, psts, rsts}, 0);
  endtask

  task automatic t_sw_entry();
    sw_write(0, 2'd1); check("R3 en=0 ignored", st, 0);
    sw_write(1, 2'd0); check("R3 type0 ignored", st, 0);
    sw_write(1, 2'd1); check("R3 enter S3", st, 1);
    check("R2 S3 lines", lines_n(), 3'b110);
    sw_write(1, 2'd3); check("R3 write outside S0 ignored", st, 1);
    pulse_wake(); check("R7 wake to S0", st, 0); check("R7 wake_sts", wsts, 1);
    clear_wsts(); check("R9 clear", wsts, 0);
    sw_write(1, 2'd2); check("R3 enter S4", st, 2);
    check("R2 S4 lines", lines_n(), 3'b100);
    pulse_wake(); check("R7 wake from S4", st, 0);
    sw_write(1, 2'd3); check("R3 enter S5", st, 3);
    check("R2 S5 lines", lines_n(), 3'b000);
    pulse_wake(); check("R7 wake from S5", st, 0);
    check("R2 S0 lines", lines_n(), 3'b111);
    clear_wsts();
  endtask

  task automatic t_thermal();
    therm = 1; cyc(); therm = 0; check("R5 thermal in S0", st, 3);
    pulse_wake(); clear_wsts();
    sw_write(1, 2'd1);
    therm = 1; cyc(); therm = 0; check("R5 thermal in S3 ignored", st, 1);
    wdt = 1; cyc(); wdt = 0; check("R6 watchdog from S3", st, 3);
    pulse_wake();
    wdt = 1; cyc(); wdt = 0; check("R6 watchdog from S0", st, 3);
    pulse_wake(); clear_wsts();
  endtask

  task automatic t_override();
    btn = 1; cyc();
    check("R12 button status", psts, 1);
    for (int i = 0; i < HOLD; i++) begin
      tick = 1; cyc(); tick = 0; cyc();
    end
    check("R4 no override at HOLD ticks", st, 0);
    tick = 1; cyc(); tick = 0;
    check("R4 override fires", st, 3);
    pulse_wake(); clear_wsts();
    for (int i = 0; i < 3; i++) begin
      tick = 1; cyc(); tick = 0; cyc();
    end
    check("R4 once per press", st, 0);
    btn = 0; cyc();
  endtask

  task automatic t_lowbatt();
    sw_write(1, 2'd1);
    low_batt = 1; pulse_wake();
    repeat (3) cyc();
    check("R8 blocked", st, 1);
    check("R8 no status", wsts, 0);
    low_batt = 0; cyc();
    check("R8 deferred wake", st, 0);
    check("R8 deferred status", wsts, 1);
    sw_write(1, 2'd1);
    wclr = 1; wake = 1; cyc(); wclr = 0; wake = 0;
    check("R9 set wins over clear", wsts, 1);
    clear_wsts();
    sw_write(1, 2'd2);
    wake = 1; wdt = 1; cyc(); wake = 0; wdt = 0;
    check("R13 force wins state", st, 3);
    check("R13 no wake status", wsts, 0);
    repeat (2) cyc();
    check("R13 wake not kept", st, 3);
    pulse_wake(); clear_wsts();
  endtask

  task automatic t_loss(logic [1:0] from, logic pol, int exp, string tag);
    if (from != 0) sw_write(1, from);
    apl = pol;
    rtc = 1; cyc(); rtc = 0;
    check("R12 rtc status", rsts, 1);
    dpg = 0; cyc();
    check({"R10 lines low ", tag}, lines_n(), 0);
    check({"R12 cleared ", tag}, {psts, rsts}, 0);
    wdt = 1; cyc(); wdt = 0;
    check({"R10 state held ", tag}, st, from);
    dpg = 1; cyc();
    check({"R11 resume ", tag}, st, exp);
    if (st != 0) pulse_wake();
    clear_wsts();
  endtask

  initial begin
    repeat (2) cyc();
    rst_n = 1; cyc();
    t_reset();
    t_sw_entry();
    t_thermal();
    t_override();
    t_lowbatt();
    t_loss(2'd0, 1, 3, "S0 pol1");
    t_loss(2'd1, 1, 3, "S3 pol1");
    t_loss(2'd2, 1, 2, "S4 pol1");
    t_loss(2'd3, 1, 3, "S5 pol1");
    t_loss(2'd2, 0, 0, "S4 pol0");
    t_loss(2'd1, 0, 0, "S3 pol0");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule